// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps the two 16-bit data pointers of an 8051-style core together with the control register that picks which of them is active. The core reaches the pointer bytes and the control register through a byte-wide special-function-register (SFR) port. The same core also pulses a set of one-cycle instruction strobes: external data move through the pointer, code read relative to the pointer, explicit pointer increment, and immediate pointer load. The unit drives the value of the active pointer onto the address path as a combinational output of its registers.

The active pointer can be stepped after a qualifying pointer move, and the selection can be flipped after one. Each pointer has its own direction bit, so one pointer can walk up through a buffer while the other walks down. Every control setting is software visible and takes effect on the cycle after the write.

Top module: `dptr_pair_unit`

## Requirements
- R1: After reset both pointers, the control register and `ptr_o` are zero.
- R2: SFR addresses 82h/83h hold the low/high byte of pointer 0 and 84h/85h those of pointer 1. A write updates the addressed byte on the next clock edge. Reads are combinational, return the current value without side effects, and any other address reads as 00h.
- R3: The control register sits at 86h. Bit 0 selects the active pointer (0 = pointer 0, 1 = pointer 1), bits 3:1 always read 0, and `ptr_o` and `sel_o` follow the selected pointer.
- R4: An explicit increment strobe steps the active pointer by +1 when its direction bit is 0 and by -1 when it is 1. Bit 6 is the direction bit of pointer 0 and bit 7 that of pointer 1. The step wraps modulo 2^16, the other pointer is left unchanged, and bit 4 has no effect on it.
- R5: With control bit 4 set, an external data move or code read steps the active pointer by its direction bit. With bit 4 clear, those strobes leave both pointers unchanged.
- R6: With control bit 5 set, an external data move, a code read or an immediate load flips bit 0 after the operation. An increment strobe never flips it, and with bit 5 clear nothing flips it.
- R7: An immediate load writes `load_val_i` into the active pointer and never steps it.
- R8: When bits 4 and 5 are both set, a qualifying move steps the pointer that was active during the move, and the selection flips afterwards.
- R9: An SFR write to a byte of a pointer in the same cycle as a step or load of that pointer wins: only the written byte changes, and the other byte keeps its old value. An SFR write to the control register in the same cycle as a flip wins as well.
- R10: The core asserts at most one instruction strobe per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_addr_i | input | 8 | SFR address for read and write |
| sfr_wr_i | input | 1 | SFR write strobe |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data for `sfr_addr_i` |
| ev_movx_i | input | 1 | External data move through the active pointer |
| ev_movc_i | input | 1 | Code read relative to the active pointer |
| ev_inc_i | input | 1 | Explicit pointer increment instruction |
| ev_load_i | input | 1 | Immediate load of the active pointer |
| load_val_i | input | 16 | Value for the immediate load |
| ptr_o | output | 16 | Active pointer value to the address path |
| sel_o | output | 1 | Index of the active pointer |

## Verification
Directed sequences first load distinct byte patterns into each pointer, so that a swapped byte lane or a swapped pointer shows up on readback. Steps are then run from 0000h and FFFFh in both directions, which separates a correct direction bit from a mixed-up one and exposes a missing wrap. Moves are issued with the advance and flip bits off, on, and both on, and the result tells a step of the old pointer apart from a step of the newly selected one. Finally, SFR writes are made to collide with steps, loads and flips, which shows which side wins and whether the unwritten byte is disturbed.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int PTR_W  = 16;
  localparam int BYTE_W = 8;
  localparam int NUM_PTR = 2;

  localparam logic [7:0] ADDR_P0_LO = 8'h82;
  localparam logic [7:0] ADDR_P0_HI = 8'h83;
  localparam logic [7:0] ADDR_P1_LO = 8'h84;
  localparam logic [7:0] ADDR_P1_HI = 8'h85;
  localparam logic [7:0] ADDR_CTRL  = 8'h86;

  // control byte layout
  localparam int BIT_SEL  = 0;
  localparam int BIT_AUTO = 4;
  localparam int BIT_TOGL = 5;
  localparam int BIT_DIR0 = 6;
  localparam int BIT_DIR1 = 7;
  localparam logic [7:0] CTRL_MASK = 8'hF1;
endpackage

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
  import dptr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              toggle_i,
  output logic [BYTE_W-1:0] ctrl_o
);
  logic [BYTE_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (wr_i)     ctrl_q <= wdata_i & CTRL_MASK;
    else if (toggle_i) ctrl_q[BIT_SEL] <= ~ctrl_q[BIT_SEL];
  end

  assign ctrl_o = ctrl_q;

  p_toggle_flips_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (toggle_i && !wr_i) |=> (ctrl_q[BIT_SEL] != $past(ctrl_q[BIT_SEL])));
  p_write_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (ctrl_q[BIT_SEL] == $past(wdata_i[BIT_SEL])));
  p_reserved_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[3:1] == 3'b000);
endmodule

// File: rtl/dptr_word.sv
module dptr_word
  import dptr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              load_i,
  input  logic [PTR_W-1:0]  load_val_i,
  input  logic              step_i,
  input  logic              step_dn_i,
  output logic [PTR_W-1:0]  q_o
);
  logic [PTR_W-1:0] q_q, stepped;

  assign stepped = step_dn_i ? q_q - PTR_W'(1) : q_q + PTR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) q_q[BYTE_W-1:0]     <= wdata_i;
      if (wr_hi_i) q_q[PTR_W-1:BYTE_W] <= wdata_i;
    end else if (load_i) begin
      q_q <= load_val_i;
    end else if (step_i) begin
      q_q <= stepped;
    end
  end

  assign q_o = q_q;

  p_lo_write_keeps_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wr_hi_i) |=> (q_q[PTR_W-1:BYTE_W] == $past(q_q[PTR_W-1:BYTE_W])));
  p_step_by_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_lo_i && !wr_hi_i && !load_i) |=>
      (q_q == ($past(step_dn_i) ? $past(q_q) - PTR_W'(1) : $past(q_q) + PTR_W'(1))));
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i && !wr_lo_i && !wr_hi_i) |=> $stable(q_q));
endmodule

// File: rtl/dptr_pair_unit.sv
module dptr_pair_unit
  import dptr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        sfr_addr_i,
  input  logic              sfr_wr_i,
  input  logic [BYTE_W-1:0] sfr_wdata_i,
  output logic [BYTE_W-1:0] sfr_rdata_o,
  input  logic              ev_movx_i,
  input  logic              ev_movc_i,
  input  logic              ev_inc_i,
  input  logic              ev_load_i,
  input  logic [PTR_W-1:0]  load_val_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              sel_o
);
  logic [BYTE_W-1:0] ctrl;
  logic [PTR_W-1:0]  ptr [NUM_PTR];
  logic              qual_move, do_step, do_toggle;
  logic              sel;

  assign sel       = ctrl[BIT_SEL];
  assign qual_move = ev_movx_i || ev_movc_i;
  assign do_step   = ev_inc_i || (ctrl[BIT_AUTO] && qual_move);
  assign do_toggle = ctrl[BIT_TOGL] && (qual_move || ev_load_i);

  dptr_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (sfr_wr_i && (sfr_addr_i == ADDR_CTRL)),
    .wdata_i  (sfr_wdata_i),
    .toggle_i (do_toggle),
    .ctrl_o   (ctrl)
  );

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    localparam logic [7:0] LO_A = (i == 0) ? ADDR_P0_LO : ADDR_P1_LO;
    localparam logic [7:0] HI_A = (i == 0) ? ADDR_P0_HI : ADDR_P1_HI;
    localparam int         DIRB = (i == 0) ? BIT_DIR0 : BIT_DIR1;
    logic active;
    assign active = (sel == 1'(i));

    dptr_word u_word (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_lo_i    (sfr_wr_i && (sfr_addr_i == LO_A)),
      .wr_hi_i    (sfr_wr_i && (sfr_addr_i == HI_A)),
      .wdata_i    (sfr_wdata_i),
      .load_i     (active && ev_load_i),
      .load_val_i (load_val_i),
      .step_i     (active && do_step),
      .step_dn_i  (ctrl[DIRB]),
      .q_o        (ptr[i])
    );
  end

  always_comb begin
    unique case (sfr_addr_i)
      ADDR_P0_LO: sfr_rdata_o = ptr[0][BYTE_W-1:0];
      ADDR_P0_HI: sfr_rdata_o = ptr[0][PTR_W-1:BYTE_W];
      ADDR_P1_LO: sfr_rdata_o = ptr[1][BYTE_W-1:0];
      ADDR_P1_HI: sfr_rdata_o = ptr[1][PTR_W-1:BYTE_W];
      ADDR_CTRL:  sfr_rdata_o = ctrl;
      default:    sfr_rdata_o = '0;
    endcase
  end

  assign ptr_o = sel ? ptr[1] : ptr[0];
  assign sel_o = sel;

  p_one_event_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ev_movx_i, ev_movc_i, ev_inc_i, ev_load_i}) <= 1);
  p_inc_no_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_inc_i && !sfr_wr_i) |=> $stable(sel_o));
  p_load_value_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_load_i && !ctrl[BIT_TOGL] && !sfr_wr_i) |=> (ptr_o == $past(load_val_i)));
endmodule

// File: tb/dptr_pair_unit_tb_top.sv
module dptr_pair_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        ev_movx = 1'b0, ev_movc = 1'b0, ev_inc = 1'b0, ev_load = 1'b0;
  logic [15:0] load_val = 16'h0000;
  logic [15:0] ptr;
  logic        sel;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  dptr_pair_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .sfr_addr_i(sfr_addr), .sfr_wr_i(sfr_wr), .sfr_wdata_i(sfr_wdata),
    .sfr_rdata_o(sfr_rdata),
    .ev_movx_i(ev_movx), .ev_movc_i(ev_movc), .ev_inc_i(ev_inc), .ev_load_i(ev_load),
    .load_val_i(load_val), .ptr_o(ptr), .sel_o(sel)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: optional SFR write together with an optional strobe
  // kind: 0 none, 1 movx, 2 movc, 3 inc, 4 load
  task automatic cyc(input bit wr, input logic [7:0] a, input logic [7:0] d,
                     input int kind, input logic [15:0] lv);
    @(negedge clk);
    sfr_wr = wr; sfr_addr = a; sfr_wdata = d;
    ev_movx = (kind == 1); ev_movc = (kind == 2);
    ev_inc = (kind == 3); ev_load = (kind == 4); load_val = lv;
    @(negedge clk);
    sfr_wr = 1'b0; ev_movx = 1'b0; ev_movc = 1'b0; ev_inc = 1'b0; ev_load = 1'b0;
  endtask

  task automatic wr_sfr(input logic [7:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 0, 16'h0);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    sfr_addr = a;
    #1;
    chk(req, {8'h00, sfr_rdata}, {8'h00, exp});
  endtask

  task automatic set_ptr(input int idx, input logic [15:0] v);
    wr_sfr(idx == 0 ? 8'h82 : 8'h84, v[7:0]);
    wr_sfr(idx == 0 ? 8'h83 : 8'h85, v[15:8]);
  endtask

  task automatic t_reset;
    chk("R1 ptr_o", ptr, 16'h0000);
    rd_chk("R1 ctrl", 8'h86, 8'h00);
    rd_chk("R1 p0 lo", 8'h82, 8'h00);
    rd_chk("R1 p1 hi", 8'h85, 8'h00);
  endtask

  task automatic t_sfr_map;
    set_ptr(0, 16'h1234);
    set_ptr(1, 16'hABCD);
    rd_chk("R2 p0 lo", 8'h82, 8'h34);
    rd_chk("R2 p0 hi", 8'h83, 8'h12);
    rd_chk("R2 p1 lo", 8'h84, 8'hCD);
    rd_chk("R2 p1 hi", 8'h85, 8'hAB);
    rd_chk("R2 unmapped", 8'h87, 8'h00);
    rd_chk("R2 reread no side effect", 8'h84, 8'hCD);
    chk("R3 ptr_o sel0", ptr, 16'h1234);
    wr_sfr(8'h86, 8'h0F);
    rd_chk("R3 reserved bits zero", 8'h86, 8'h01);
    chk("R3 ptr_o sel1", ptr, 16'hABCD);
    chk("R3 sel_o", {15'h0, sel}, 16'h0001);
    wr_sfr(8'h86, 8'h00);
  endtask

  task automatic t_inc;
    cyc(1'b0, 8'h00, 8'h00, 3, 16'h0);
    chk("R4 inc up", ptr, 16'h1235);
    wr_sfr(8'h86, 8'h40);
    cyc(1'b0, 8'h00, 8'h00, 3, 16'h0);
    chk("R4 dec via bit6", ptr, 16'h1234);
    set_ptr(0, 16'h0000);
    cyc(1'b0, 8'h00, 8'h00, 3, 16'h0);
    chk("R4 dec wrap", ptr, 16'hFFFF);
    wr_sfr(8'h86, 8'h80);
    cyc(1'b0, 8'h00, 8'h00, 3, 16'h0);
    chk("R4 inc wrap, bit7 not p0", ptr, 16'h0000);
    wr_sfr(8'h86, 8'h81);
    cyc(1'b0, 8'h00, 8'h00, 3, 16'h0);
    chk("R4 p1 dec via bit7", ptr, 16'hABCC);
    wr_sfr(8'h86, 8'h00);
    chk("R4 other pointer untouched", ptr, 16'h0000);
  endtask

  task automatic t_auto;
    set_ptr(0, 16'h0100);
    cyc(1'b0, 8'h00, 8'h00, 1, 16'h0);
    chk("R5 movx no advance when off", ptr, 16'h0100);
    wr_sfr(8'h86, 8'h10);
    cyc(1'b0, 8'h00, 8'h00, 1, 16'h0);
    chk("R5 movx advance", ptr, 16'h0101);
    cyc(1'b0, 8'h00, 8'h00, 2, 16'h0);
    chk("R5 movc advance", ptr, 16'h0102);
    wr_sfr(8'h86, 8'h91);
    cyc(1'b0, 8'h00, 8'h00, 2, 16'h0);
    chk("R5 p1 movc down", ptr, 16'hABCB);
    wr_sfr(8'h86, 8'h00);
    rd_chk("R5 p0 kept", 8'h82, 8'h02);
  endtask

  task automatic t_toggle;
    wr_sfr(8'h86, 8'h20);
    cyc(1'b0, 8'h00, 8'h00, 1, 16'h0);
    rd_chk("R6 movx toggles", 8'h86, 8'h21);
    chk("R6 no advance without bit4", ptr, 16'hABCB);
    cyc(1'b0, 8'h00, 8'h00, 4, 16'h5555);
    rd_chk("R6 load toggles", 8'h86, 8'h20);
    rd_chk("R7 load into p1 lo", 8'h84, 8'h55);
    rd_chk("R7 load into p1 hi", 8'h85, 8'h55);
    cyc(1'b0, 8'h00, 8'h00, 3, 16'h0);
    chk("R6 inc does not toggle", {15'h0, sel}, 16'h0000);
    chk("R4 inc p0", ptr, 16'h0103);
    wr_sfr(8'h86, 8'h00);
    cyc(1'b0, 8'h00, 8'h00, 4, 16'h7777);
    chk("R7 load, no toggle when off", ptr, 16'h7777);
    chk("R6 sel held", {15'h0, sel}, 16'h0000);
  endtask

  task automatic t_combined;
    set_ptr(0, 16'h0010);
    set_ptr(1, 16'h0100);
    wr_sfr(8'h86, 8'h30);
    cyc(1'b0, 8'h00, 8'h00, 1, 16'h0);
    chk("R8 now on p1", ptr, 16'h0100);
    rd_chk("R8 old pointer advanced", 8'h82, 8'h11);
    cyc(1'b0, 8'h00, 8'h00, 2, 16'h0);
    chk("R8 back on p0", ptr, 16'h0011);
    rd_chk("R8 p1 advanced", 8'h84, 8'h01);
  endtask

  task automatic t_conflict;
    wr_sfr(8'h86, 8'h10);
    set_ptr(0, 16'h12FF);
    cyc(1'b1, 8'h82, 8'h00, 1, 16'h0);
    chk("R9 sfr lo write beats advance", ptr, 16'h1200);
    cyc(1'b1, 8'h83, 8'h44, 4, 16'h9999);
    chk("R9 sfr hi write beats load", ptr, 16'h4400);
    wr_sfr(8'h86, 8'h20);
    cyc(1'b1, 8'h86, 8'h20, 1, 16'h0);
    chk("R9 ctrl write beats toggle", {15'h0, sel}, 16'h0000);
    wr_sfr(8'h86, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_sfr_map();
    t_inc();
    t_auto();
    t_toggle();
    t_combined();
    t_conflict();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule